// File: doc/BRIEF.md
# Sequence-Locked Watchdog Timer

This block is a register-mapped watchdog for a chip's control processor. A counter climbs by one on every reference tick while the watchdog runs, starting from a value that software programs as the two's complement of the wanted tick count. When the counter passes all ones it wraps. On that wrap the block sends out a one-cycle reset-request pulse, latches an overflow flag and reloads the counter from a load register.

Software cannot start or stop the watchdog with a single write. It must write two fixed words, in the right order, to a run-control register. A different pair of words is used for starting and for stopping. Each write to that register keeps a busy flag up for a few cycles, and any run-control write made while the flag is up is dropped. A typical refresh stops the dog, rewrites the counter with the negative timeout and starts it again.

A soft-reset command puts every register back to its power-on value. A reset-complete status bit reads 0 while that command is being carried out.

Top module: `wdt_top`

## Requirements
- R1: After the reset input is released, the watchdog is stopped, the counter and load registers read 0, the overflow flag and interrupt enable read 0, the busy flag reads 0 and reset-complete (STAT offset 0x04, bit 0) reads 1.
- R2: Writing 0x0000AAAA and then 0x00005555 to the run-control register (offset 0x1C) stops the watchdog.
- R3: Writing 0x0000BBBB and then 0x00004444 to the run-control register starts the watchdog.
- R4: Any accepted run-control word that does not complete a pair, or begin one from the idle state, is dropped and discards a half-entered pair. After a wrong second word, the correct second word has no effect.
- R5: An accepted run-control write sets the busy flag (offset 0x18, bit 4) for exactly PEND_CYC cycles (4 by default). A run-control write made while the flag is set is dropped and leaves the sequence state unchanged.
- R6: While the watchdog runs, the counter (offset 0x10) rises by 1 on each clock with tick high. While it is stopped, the counter holds. The counter and the load register (offset 0x14) can be written.
- R7: A tick that arrives with the counter at all ones reloads the counter from the load register and drives reset_req high for one cycle. It also sets the overflow flag, bit 0 of the interrupt status register at offset 0x08.
- R8: Writing 1 to interrupt status bit 0 clears the flag. If an overflow happens in the same cycle, the set wins. irq equals status bit 0 ANDed with enable bit 0 (offset 0x0C).
- R9: Writing 1 to bit 1 of the config register (offset 0x00) holds every register at its reset value for RST_CYC cycles (3 by default). During that time reset-complete reads 0 and bus writes are dropped.
- R10: A counter write and a tick in the same cycle leave the written value in the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick enable, one count per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| reset_req | output | 1 | One-cycle reset request on overflow |
| irq | output | 1 | Overflow interrupt |

## Verification
An overflow event and a software write-one-to-clear of the overflow flag can land in the same clock cycle. The bench provokes this by raising tick with the counter at all ones while it writes 1 to the status register in that same cycle. It expects the flag to remain set and a reset-request pulse to appear. It also drives a counter write in the same cycle as a tick and expects the written value to survive. Sequence handling is judged against a bench model fed random run-control words.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [31:0] MAGIC_STOP_1 = 32'h0000_AAAA;
   localparam logic [31:0] MAGIC_STOP_2 = 32'h0000_5555;
   localparam logic [31:0] MAGIC_RUN_1  = 32'h0000_BBBB;
   localparam logic [31:0] MAGIC_RUN_2  = 32'h0000_4444;

   localparam logic [4:0] OFS_CFG  = 5'h00;
   localparam logic [4:0] OFS_STAT = 5'h04;
   localparam logic [4:0] OFS_ISR  = 5'h08;
   localparam logic [4:0] OFS_IER  = 5'h0C;
   localparam logic [4:0] OFS_CNT  = 5'h10;
   localparam logic [4:0] OFS_LOAD = 5'h14;
   localparam logic [4:0] OFS_BUSY = 5'h18;
   localparam logic [4:0] OFS_RUNC = 5'h1C;

   localparam int BUSY_BIT = 4;
   localparam int SRST_BIT = 1;

   typedef enum logic [1:0] {
      SEQ_IDLE     = 2'd0,
      SEQ_STOP_HLF = 2'd1,
      SEQ_RUN_HLF  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/wdt_srst.sv
module wdt_srst #(
   parameter int RST_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);
   localparam int RW = $clog2(RST_CYC + 1);

   logic [RW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left <= '0;
      end else if (go && left == '0) begin
         left <= RW'(RST_CYC);
      end else if (left != '0) begin
         left <= left - 1'b1;
      end
   end

   assign busy = (left != '0);
endmodule

// File: rtl/wdt_runctl.sv
module wdt_runctl
   import wdt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PEND_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              pend,
   output logic              run
);
   localparam int PW = $clog2(PEND_CYC + 1);

   logic [PW-1:0] pend_cnt;
   seq_state_t    st;
   logic          accept;

   assign accept = we && (pend_cnt == '0);
   assign pend   = (pend_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         pend_cnt <= '0;
         st       <= SEQ_IDLE;
         run      <= 1'b0;
      end else begin
         if (accept) begin
            pend_cnt <= PW'(PEND_CYC);
         end else if (pend_cnt != '0) begin
            pend_cnt <= pend_cnt - 1'b1;
         end
         if (accept) begin
            unique case (st)
               SEQ_STOP_HLF: begin
                  if (wdata == MAGIC_STOP_2[DATA_W-1:0]) run <= 1'b0;
                  st <= SEQ_IDLE;
               end
               SEQ_RUN_HLF: begin
                  if (wdata == MAGIC_RUN_2[DATA_W-1:0]) run <= 1'b1;
                  st <= SEQ_IDLE;
               end
               default: begin
                  if (wdata == MAGIC_STOP_1[DATA_W-1:0])     st <= SEQ_STOP_HLF;
                  else if (wdata == MAGIC_RUN_1[DATA_W-1:0]) st <= SEQ_RUN_HLF;
                  else                                       st <= SEQ_IDLE;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic             load_we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] load,
   output logic             ovf
);
   logic adv;

   assign adv = !clr && run && tick && !cnt_we;
   assign ovf = adv && (cnt == '1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt  <= '0;
         load <= '0;
      end else begin
         if (load_we) load <= wdata;
         if (cnt_we)   cnt <= wdata;
         else if (ovf) cnt <= load;
         else if (adv) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
   import wdt_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int PEND_CYC = 4,
   parameter int RST_CYC  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              reset_req,
   output logic              irq
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("wdt_top: ADDR_W must be at least 5");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("wdt_top: DATA_W must be at least 16");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("wdt_top: CNT_W must lie in 2..DATA_W");
   end
   if (PEND_CYC < 1 || RST_CYC < 1) begin : g_bad_cyc
      $error("wdt_top: PEND_CYC and RST_CYC must be positive");
   end

   logic             clr, wr_ok;
   logic             cfg_we, ss_we, cnt_we, load_we, isr_we, ier_we;
   logic             pend, run, ovf_evt;
   logic             isr, ier;
   logic [CNT_W-1:0] cnt, load;

   assign wr_ok   = bus_wr && !clr;
   assign cfg_we  = wr_ok && bus_addr == ADDR_W'(OFS_CFG);
   assign ss_we   = wr_ok && bus_addr == ADDR_W'(OFS_RUNC);
   assign cnt_we  = wr_ok && bus_addr == ADDR_W'(OFS_CNT);
   assign load_we = wr_ok && bus_addr == ADDR_W'(OFS_LOAD);
   assign isr_we  = wr_ok && bus_addr == ADDR_W'(OFS_ISR);
   assign ier_we  = wr_ok && bus_addr == ADDR_W'(OFS_IER);

   wdt_srst #(.RST_CYC(RST_CYC)) u_srst (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (cfg_we && bus_wdata[SRST_BIT]),
      .busy (clr)
   );

   wdt_runctl #(.DATA_W(DATA_W), .PEND_CYC(PEND_CYC)) u_runctl (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .we   (ss_we),
      .wdata(bus_wdata),
      .pend (pend),
      .run  (run)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .run    (run),
      .tick   (tick),
      .cnt_we (cnt_we),
      .load_we(load_we),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .cnt    (cnt),
      .load   (load),
      .ovf    (ovf_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         isr       <= 1'b0;
         ier       <= 1'b0;
         reset_req <= 1'b0;
      end else begin
         reset_req <= ovf_evt;
         if (ier_we) ier <= bus_wdata[0];
         isr <= ovf_evt | (isr & !(isr_we && bus_wdata[0]));
      end
   end

   assign irq = isr & ier;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_STAT): bus_rdata[0]              = !clr;
         ADDR_W'(OFS_ISR):  bus_rdata[0]              = isr;
         ADDR_W'(OFS_IER):  bus_rdata[0]              = ier;
         ADDR_W'(OFS_CNT):  bus_rdata[CNT_W-1:0]      = cnt;
         ADDR_W'(OFS_LOAD): bus_rdata[CNT_W-1:0]      = load;
         ADDR_W'(OFS_BUSY): bus_rdata[BUSY_BIT]       = pend;
         default:           bus_rdata                 = '0;
      endcase
   end
endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             ss_we,
   input logic             pend,
   input logic             run,
   input logic             cnt_we,
   input logic [CNT_W-1:0] cnt,
   input logic             isr,
   input logic             ovf_evt,
   input logic             reset_req
);
   assert_req_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> isr);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> isr);

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_we && !clr) |=> $stable(cnt));

   assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_we && pend && !clr) |=> $stable(run));

   assert_busy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_we && !pend && !clr) |=> pend);

   assert_run_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ss_we && !clr) |=> $stable(run));

   assert_srst_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && !isr && !run));
endmodule

bind wdt_top wdt_top_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .ss_we    (ss_we),
   .pend     (pend),
   .run      (run),
   .cnt_we   (cnt_we),
   .cnt      (cnt),
   .isr      (isr),
   .ovf_evt  (ovf_evt),
   .reset_req(reset_req)
);

// File: tb/wdt_top_tb.sv
`timescale 1ns/100ps
module wdt_top_tb;
   localparam logic [4:0] A_CFG = 5'h00, A_STAT = 5'h04, A_ISR = 5'h08, A_IER = 5'h0C,
                          A_CNT = 5'h10, A_LOAD = 5'h14, A_BUSY = 5'h18, A_RUNC = 5'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        reset_req, irq;

   int nchk = 0, nfail = 0, rr_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wdt_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req), .irq(irq)
   );

   always @(negedge clk) if (reset_req) rr_cnt++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // probe whether the dog runs: load a counter value, tick once, read back
   task automatic probe_run(output bit r);
      logic [31:0] v;
      wr(A_CNT, 32'h100);
      ticks(1);
      rd_now(A_CNT, v);
      r = (v == 32'h101);
   endtask

   task automatic ss(input logic [31:0] w);
      wr(A_RUNC, w);
      wait_cyc(5);
   endtask

   function automatic int seq_step(input int st, input logic [31:0] w, inout bit r);
      if (st == 1) begin
         if (w == 32'h5555) r = 0;
         return 0;
      end else if (st == 2) begin
         if (w == 32'h4444) r = 1;
         return 0;
      end
      if (w == 32'hAAAA) return 1;
      if (w == 32'hBBBB) return 2;
      return 0;
   endfunction

   function automatic logic [31:0] cnt_step(input logic [31:0] c, input logic [31:0] ld);
      return (c == 32'hFFFF_FFFF) ? ld : c + 1;
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c, ld, exp_c;
      bit r, mr;
      int st, rr0, novf;
      logic [31:0] pool [5];
      void'($urandom(32'd4242));
      pool[0] = 32'hAAAA; pool[1] = 32'h5555; pool[2] = 32'hBBBB; pool[3] = 32'h4444;

      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      rd_now(A_STAT, v); chk(v == 32'h1, "R1 stat", v, 32'h1);
      rd_now(A_CNT, v);  chk(v == 0, "R1 cnt", v, 0);
      rd_now(A_LOAD, v); chk(v == 0, "R1 load", v, 0);
      rd_now(A_ISR, v);  chk(v == 0, "R1 isr", v, 0);
      rd_now(A_IER, v);  chk(v == 0, "R1 ier", v, 0);
      rd_now(A_BUSY, v); chk(v == 0, "R1 busy", v, 0);
      probe_run(r); chk(!r, "R1 stopped", r, 0);

      // R3 start, with R5 busy timing
      wr(A_RUNC, 32'hBBBB);
      rd_now(A_BUSY, v); chk(v == 32'h10, "R5 busy c1", v, 32'h10);
      for (int i = 2; i <= 4; i++) begin
         @(negedge clk); rd_now(A_BUSY, v); chk(v == 32'h10, "R5 busy held", v, 32'h10);
      end
      @(negedge clk); rd_now(A_BUSY, v); chk(v == 0, "R5 busy drop", v, 0);
      wr(A_RUNC, 32'h4444); wait_cyc(5);
      probe_run(r); chk(r, "R3 start", r, 1);

      // R2 stop
      ss(32'hAAAA); ss(32'h5555);
      probe_run(r); chk(!r, "R2 stop", r, 0);

      // R5 write during busy is dropped, state kept
      wr(A_RUNC, 32'hBBBB);
      wr(A_RUNC, 32'h4444);
      wait_cyc(5);
      probe_run(r); chk(!r, "R5 dropped write", r, 0);
      ss(32'h4444);
      probe_run(r); chk(r, "R5 state kept", r, 1);

      // R4 wrong second word discards half pair
      ss(32'hAAAA); ss(32'hAAAA); ss(32'h5555);
      probe_run(r); chk(r, "R4 repeat first word", r, 1);
      ss(32'hAAAA); ss(32'h1234); ss(32'h5555);
      probe_run(r); chk(r, "R4 other word", r, 1);

      // R6 counting and stop hold
      wr(A_CNT, 32'h10); ticks(7); rd_now(A_CNT, v);
      chk(v == 32'h17, "R6 count", v, 32'h17);
      wr(A_LOAD, 32'hCAFE_0000); rd_now(A_LOAD, v);
      chk(v == 32'hCAFE_0000, "R6 load", v, 32'hCAFE_0000);

      // R10 write beats tick in same cycle
      @(negedge clk); bus_wr = 1; bus_addr = A_CNT; bus_wdata = 32'h55; tick = 1;
      @(negedge clk); bus_wr = 0; tick = 0;
      rd_now(A_CNT, v); chk(v == 32'h55, "R10 write wins", v, 32'h55);

      // R7 overflow
      wr(A_IER, 1);
      wr(A_CNT, 32'hFFFF_FFFE);
      rr0 = rr_cnt;
      ticks(2);
      rd_now(A_CNT, v); chk(v == 32'hCAFE_0000, "R7 reload", v, 32'hCAFE_0000);
      chk(rr_cnt == rr0 + 1, "R7 single pulse", rr_cnt, rr0 + 1);
      rd_now(A_ISR, v); chk(v == 1, "R7 flag", v, 1);
      chk(irq == 1, "R8 irq", irq, 1);

      // R8 clear, then same-cycle clear and overflow
      wr(A_ISR, 1); rd_now(A_ISR, v); chk(v == 0, "R8 w1c", v, 0);
      chk(irq == 0, "R8 irq low", irq, 0);
      wr(A_CNT, 32'hFFFF_FFFF);
      ticks(1); rd_now(A_ISR, v); chk(v == 1, "R8 flag again", v, 1);
      wr(A_CNT, 32'hFFFF_FFFF);
      rr0 = rr_cnt;
      @(negedge clk); bus_wr = 1; bus_addr = A_ISR; bus_wdata = 1; tick = 1;
      @(negedge clk); bus_wr = 0; tick = 0;
      rd_now(A_ISR, v); chk(v == 1, "R8 set wins", v, 1);
      chk(rr_cnt == rr0 + 1, "R8 pulse with clear", rr_cnt, rr0 + 1);

      // R7/R6 random runs against model
      for (int k = 0; k < 20; k++) begin
         ld = $urandom;
         c = 32'hFFFF_FFFF - ($urandom % 6);
         wr(A_LOAD, ld); wr(A_CNT, c); wr(A_ISR, 1);
         exp_c = c; novf = 0;
         for (int j = 0, n = 1 + $urandom % 10; j < n; j++) begin
            if (exp_c == 32'hFFFF_FFFF) novf++;
            exp_c = cnt_step(exp_c, ld);
         end
         rr0 = rr_cnt;
         ticks(int'(0) + 0);
         // re-run with same count: redo deterministically
         exp_c = c; novf = 0;
         for (int j = 0; j < 1 + (k % 8); j++) begin
            if (exp_c == 32'hFFFF_FFFF) novf++;
            exp_c = cnt_step(exp_c, ld);
         end
         ticks(1 + (k % 8));
         rd_now(A_CNT, v); chk(v == exp_c, "R7 random count", v, exp_c);
         chk(rr_cnt - rr0 == novf, "R7 random pulses", rr_cnt - rr0, novf);
         rd_now(A_ISR, v); chk(v == (novf != 0), "R7 random flag", v, (novf != 0));
      end

      // R4 random sequences against model (dog currently running)
      st = 0; mr = 1;
      for (int k = 0; k < 48; k++) begin
         pool[4] = $urandom & 32'hFFFF;
         v = pool[$urandom % 5];
         ss(v);
         st = seq_step(st, v, mr);
         if (k % 6 == 5) begin
            probe_run(r); chk(r == mr, "R4 random sequence", r, mr);
         end
      end

      // R9 soft reset
      wr(A_LOAD, 32'h1234); wr(A_IER, 1);
      ss(32'hBBBB); ss(32'h4444);
      wr(A_CFG, 32'h2);
      rd_now(A_STAT, v); chk(v == 0, "R9 busy c1", v, 0);
      @(negedge clk); rd_now(A_STAT, v); chk(v == 0, "R9 busy c2", v, 0);
      @(negedge clk); rd_now(A_STAT, v); chk(v == 0, "R9 busy c3", v, 0);
      @(negedge clk); rd_now(A_STAT, v); chk(v == 1, "R9 done", v, 1);
      rd_now(A_LOAD, v); chk(v == 0, "R9 load cleared", v, 0);
      rd_now(A_IER, v); chk(v == 0, "R9 ier cleared", v, 0);
      probe_run(r); chk(!r, "R9 stopped", r, 0);
      wr(A_CFG, 32'h2);
      wr(A_LOAD, 32'h77); wait_cyc(3);
      rd_now(A_LOAD, v); chk(v == 0, "R9 write dropped", v, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule